// File: doc/BRIEF.md
# Indirect Register Window Controller

This block is the register front end of an interrupt redirection unit. A bus master reaches every internal register through two addresses: an index register that selects a target, and a 32-bit data window that reads or writes the selected target. The targets are an identifier register, a read-only version word, an arbitration word that mirrors the identifier, and a table of 64-bit redirection entries. Each entry is reached as a low half and a high half. A separate address takes a direct end-of-interrupt write and forwards its vector when the configured version supports that feature.

The table has one 64-bit entry per interrupt pin. The block keeps two status bits in each entry that software cannot write. A status port updates these two bits, and it is driven by the delivery and acknowledge logic that sits outside this block. Every accepted entry write sends a service-request strobe to the delivery engine and a counter-clear strobe that names the pin. A lookup port gives the message generator the whole entry for any pin. The delivery engine, the message generator and the acknowledge engine are not part of this block; it only emits their strobes.

Top module: `riw_ctrl`

## Requirements
- R1: After reset the index register and identifier are zero, every entry reads 0x0000_0000_0001_0000 (only the mask bit, bit 16, set), and rd_valid, svc_req, cnt_clr and eoi_valid are low.
- R2: Only acc_addr[7:0] is decoded: offset 0x00 is the index register (8 bits, any size, read as zero-extended), offset 0x10 is the data window, offset 0x40 is the end-of-interrupt register, and any other offset reads 0 and ignores writes.
- R3: A window or end-of-interrupt access whose acc_size is not 4 has no effect, and a window read of that kind returns 0.
- R4: Index 0 and index 2 both read the identifier in bits 27:24 with all other bits zero. A window write at index 0 stores only wdata[27:24]. Window writes at indices 1 and 2 change nothing.
- R5: Index 1 reads the version in bits 7:0 and NUM_PINS-1 in bits 23:16, with all other bits zero.
- R6: Index 0x10+2n reaches bits 31:0 of entry n, and index 0x11+2n reaches bits 63:32. An index that maps to no entry, or an index from 3 to 0x0F, reads 0 and ignores writes without any strobe.
- R7: Bit 12 (delivery status) and bit 14 (remote request) of an entry keep their values across window writes. The status port (st_valid, st_pin, st_dlv, st_rirr) sets both bits of the selected entry.
- R8: After any window write to an entry, bit 14 is cleared if the resulting bit 15 (trigger mode, 1 = level) is 0.
- R9: The cycle after an accepted entry write, svc_req and cnt_clr pulse high for one cycle and cnt_pin holds the entry number.
- R10: A 4-byte write to the end-of-interrupt register pulses eoi_valid with eoi_vec = wdata[7:0] the next cycle only when the version is 0x20. VERSION accepts 0x11 or 0x20, and any other value acts as 0x20.
- R11: Every read access is answered the next cycle with rd_valid high and rd_data holding the result. rd_data is 0 in cycles with no read response.
- R12: look_entry returns the full 64-bit entry selected by look_pin in the same cycle, and 0 for a pin number that is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Bus access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| st_valid | input | 1 | Status bit update strobe |
| st_pin | input | PIN_W | Entry targeted by the status update |
| st_dlv | input | 1 | New delivery-status bit |
| st_rirr | input | 1 | New remote-request bit |
| look_pin | input | PIN_W | Entry selected for lookup |
| look_entry | output | 64 | Selected entry contents |
| svc_req | output | 1 | Service pass request after an entry write |
| cnt_clr | output | 1 | Successive-acknowledge counter clear strobe |
| cnt_pin | output | PIN_W | Pin whose counter is cleared |
| eoi_valid | output | 1 | End-of-interrupt broadcast strobe |
| eoi_vec | output | 8 | Broadcast vector |

## Verification
The bound checker follows the index register from the bus alone and checks on every cycle how each access leads to the strobes: the size gate, the service and counter-clear pulse with the right pin, the absence of strobes for indices outside the table, the end-of-interrupt forwarding that depends on the version, and the read response timing. The behaviours that depend on stored contents can only be shown by the bench's scenarios, because they need a sequence of accesses. These are the preservation of the two status bits, the clearing of the remote-request bit on edge-triggered entries, the assembly of an entry from its two halves, the identifier masking, and address aliasing above bit 7. The bench runs a second instance at version 0x11 to show that the end-of-interrupt register is gated and that the version word differs.

// File: rtl/riw_pkg.sv
// Package riw_pkg: shared offsets, index codes, entry bit positions and the
// decoded access kind used by the indirect register window controller.
package riw_pkg;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
    localparam logic [7:0] IDX_TBL = 8'h10;

    localparam int ENT_DLV_BIT  = 12;
    localparam int ENT_RIRR_BIT = 14;
    localparam int ENT_TRIG_BIT = 15;
    localparam int ENT_MASK_BIT = 16;

    localparam int ID_LSB = 24;
    localparam int ID_W   = 4;
    localparam int CNT_LSB = 16;

    localparam logic [63:0] ENT_RO_MASK = (64'd1 << ENT_DLV_BIT) | (64'd1 << ENT_RIRR_BIT);
    localparam logic [63:0] ENT_RST     = 64'd1 << ENT_MASK_BIT;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_ENT,
        K_NONE
    } idx_kind_t;

endpackage

// File: rtl/riw_decode.sv
// Module riw_decode: turns one bus access plus the current index register
// into access classes and an entry selection.
// Assumes: the access is a single-cycle strobe; only addr[7:0] is given.
module riw_decode #(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [7:0]       addr8,
    input  logic [2:0]       acc_size,
    input  logic [7:0]       idx,
    output logic             sel_wr,
    output logic             sel_rd,
    output logic             win_wr,
    output logic             win_rd,
    output logic             eoi_wr,
    output logic             rd_any,
    output riw_pkg::idx_kind_t kind,
    output logic [PIN_W-1:0] ent_pin,
    output logic             ent_hi
);
    import riw_pkg::*;

    logic       size_ok;
    logic [7:0] ent_raw;

    // Classify the access by offset, direction and size.
    always_comb begin
        size_ok = (acc_size == 3'd4);
        sel_wr  = acc_valid &&  acc_write && (addr8 == OFF_SEL);
        sel_rd  = acc_valid && !acc_write && (addr8 == OFF_SEL);
        win_wr  = acc_valid &&  acc_write && (addr8 == OFF_WIN) && size_ok;
        win_rd  = acc_valid && !acc_write && (addr8 == OFF_WIN) && size_ok;
        eoi_wr  = acc_valid &&  acc_write && (addr8 == OFF_EOI) && size_ok;
        rd_any  = acc_valid && !acc_write;
    end

    // Map the index register onto a target and, for the table, an entry half.
    always_comb begin
        ent_raw = (idx - IDX_TBL) >> 1;
        ent_pin = ent_raw[PIN_W-1:0];
        ent_hi  = idx[0];
        if (idx == IDX_ID)
            kind = K_ID;
        else if (idx == IDX_VER)
            kind = K_VER;
        else if (idx == IDX_ARB)
            kind = K_ARB;
        else if (idx >= IDX_TBL && 32'(ent_raw) < NUM_PINS)
            kind = K_ENT;
        else
            kind = K_NONE;
    end
endmodule

// File: rtl/riw_table.sv
// Module riw_table: storage for the redirection entries.
// Window writes merge one half and keep the two status bits. The status port
// sets those bits. Edge-triggered entries lose the remote-request bit on a write.
// Assumes: wr_pin and rd_pin are in range whenever they are used.
module riw_table #(
    parameter int NUM_PINS = 24,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PIN_W-1:0] wr_pin,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic             st_valid,
    input  logic [PIN_W-1:0] st_pin,
    input  logic             st_dlv,
    input  logic             st_rirr,
    input  logic [PIN_W-1:0] rd_pin,
    input  logic             rd_hi,
    output logic [31:0]      rd_word,
    input  logic [PIN_W-1:0] look_pin,
    output logic [63:0]      look_entry
);
    import riw_pkg::*;

    logic [63:0] ent_q [NUM_PINS];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        logic        wr_hit;
        logic        st_hit;
        logic [63:0] merged;
        logic [63:0] ro_src;
        logic [63:0] wr_next;

        // Build the value an accepted window write leaves in this entry.
        always_comb begin
            wr_hit = wr_en && (wr_pin == PIN_W'(g));
            st_hit = st_valid && (st_pin == PIN_W'(g));
            merged = wr_hi ? {wr_data, ent_q[g][31:0]} : {ent_q[g][63:32], wr_data};
            ro_src = ent_q[g];
            if (st_hit) begin
                ro_src[ENT_DLV_BIT]  = st_dlv;
                ro_src[ENT_RIRR_BIT] = st_rirr;
            end
            wr_next = (merged & ~ENT_RO_MASK) | (ro_src & ENT_RO_MASK);
            if (!wr_next[ENT_TRIG_BIT])
                wr_next[ENT_RIRR_BIT] = 1'b0;
        end

        // Entry register: reset masked, then window write or status update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= ENT_RST;
            else if (wr_hit)
                ent_q[g] <= wr_next;
            else if (st_hit) begin
                ent_q[g][ENT_DLV_BIT]  <= st_dlv;
                ent_q[g][ENT_RIRR_BIT] <= st_rirr;
            end
        end
    end

    // Window read port: one 32-bit half of the selected entry.
    always_comb begin
        rd_word = rd_hi ? ent_q[rd_pin][63:32] : ent_q[rd_pin][31:0];
    end

    // Lookup port for the message generator; out-of-range pins read zero.
    always_comb begin
        look_entry = (32'(look_pin) < NUM_PINS) ? ent_q[look_pin] : 64'd0;
    end
endmodule

// File: rtl/riw_rdmux.sv
// Module riw_rdmux: forms the read value for the index register and the
// data window from the decoded target.
// Assumes: at most one of sel_rd and win_rd is high.
module riw_rdmux #(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VER      = 8'h20
) (
    input  logic                       sel_rd,
    input  logic                       win_rd,
    input  riw_pkg::idx_kind_t         kind,
    input  logic [7:0]                 idx,
    input  logic [riw_pkg::ID_W-1:0]   id,
    input  logic [31:0]                ent_word,
    output logic [31:0]                val
);
    import riw_pkg::*;

    localparam logic [7:0] MAX_ENT = 8'(NUM_PINS - 1);

    logic [31:0] win_val;

    // Value of the target that the window currently selects.
    always_comb begin
        case (kind)
            K_ID, K_ARB: win_val = 32'(id) << ID_LSB;
            K_VER:       win_val = (32'(MAX_ENT) << CNT_LSB) | 32'(VER);
            K_ENT:       win_val = ent_word;
            default:     win_val = 32'd0;
        endcase
    end

    // Select between the index register and the window; anything else reads zero.
    always_comb begin
        if (sel_rd)
            val = {24'd0, idx};
        else if (win_rd)
            val = win_val;
        else
            val = 32'd0;
    end
endmodule

// File: rtl/riw_ctrl.sv
// Module riw_ctrl: indirect register window controller (top).
// It holds the index and identifier registers, decodes bus accesses, updates
// the redirection table and registers the read response and the strobes for
// the service, counter-clear and end-of-interrupt logic outside the block.
// Assumes: NUM_PINS <= 120 so every entry is reachable from an 8-bit index.
module riw_ctrl #(
    parameter int         NUM_PINS = 24,
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] VERSION  = 8'h20,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              st_valid,
    input  logic [PIN_W-1:0]  st_pin,
    input  logic              st_dlv,
    input  logic              st_rirr,
    input  logic [PIN_W-1:0]  look_pin,
    output logic [63:0]       look_entry,
    output logic              svc_req,
    output logic              cnt_clr,
    output logic [PIN_W-1:0]  cnt_pin,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vec
);
    import riw_pkg::*;

    localparam logic [7:0] VER_EFF = (VERSION == 8'h11) ? 8'h11 : 8'h20;
    localparam bit         EOI_EN  = (VER_EFF == 8'h20);

    logic [7:0]       idx_q;
    logic [ID_W-1:0]  id_q;
    logic             sel_wr, sel_rd, win_wr, win_rd, eoi_wr, rd_any;
    idx_kind_t        kind;
    logic [PIN_W-1:0] ent_pin;
    logic             ent_hi;
    logic             ent_wr;
    logic [31:0]      ent_word;
    logic [31:0]      rd_val;

    riw_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .addr8     (acc_addr[7:0]),
        .acc_size  (acc_size),
        .idx       (idx_q),
        .sel_wr    (sel_wr),
        .sel_rd    (sel_rd),
        .win_wr    (win_wr),
        .win_rd    (win_rd),
        .eoi_wr    (eoi_wr),
        .rd_any    (rd_any),
        .kind      (kind),
        .ent_pin   (ent_pin),
        .ent_hi    (ent_hi)
    );

    // An entry write is a window write while the index points into the table.
    always_comb begin
        ent_wr = win_wr && (kind == K_ENT);
    end

    riw_table #(.NUM_PINS(NUM_PINS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ent_wr),
        .wr_pin     (ent_pin),
        .wr_hi      (ent_hi),
        .wr_data    (acc_wdata),
        .st_valid   (st_valid),
        .st_pin     (st_pin),
        .st_dlv     (st_dlv),
        .st_rirr    (st_rirr),
        .rd_pin     (ent_pin),
        .rd_hi      (ent_hi),
        .rd_word    (ent_word),
        .look_pin   (look_pin),
        .look_entry (look_entry)
    );

    riw_rdmux #(.NUM_PINS(NUM_PINS), .VER(VER_EFF)) u_rdmux (
        .sel_rd   (sel_rd),
        .win_rd   (win_rd && kind != K_NONE),
        .kind     (kind),
        .idx      (idx_q),
        .id       (id_q),
        .ent_word (ent_word),
        .val      (rd_val)
    );

    // Index register and identifier field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 8'd0;
            id_q  <= '0;
        end else begin
            if (sel_wr)
                idx_q <= acc_wdata[7:0];
            if (win_wr && kind == K_ID)
                id_q <= acc_wdata[ID_LSB +: ID_W];
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'd0;
        end else begin
            rd_valid <= rd_any;
            rd_data  <= rd_any ? rd_val : 32'd0;
        end
    end

    // Strobes to the service, counter and acknowledge logic outside the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_req   <= 1'b0;
            cnt_clr   <= 1'b0;
            cnt_pin   <= '0;
            eoi_valid <= 1'b0;
            eoi_vec   <= 8'd0;
        end else begin
            svc_req   <= ent_wr;
            cnt_clr   <= ent_wr;
            if (ent_wr)
                cnt_pin <= ent_pin;
            eoi_valid <= eoi_wr && EOI_EN;
            if (eoi_wr && EOI_EN)
                eoi_vec <= acc_wdata[7:0];
        end
    end
endmodule

// File: rtl/riw_ctrl_chk.sv
// Module riw_ctrl_chk: protocol checker for riw_ctrl. It keeps its own copy
// of the index register, built from bus writes only, and relates each access
// to the strobes and read responses of the next cycle.
module riw_ctrl_chk #(
    parameter int         NUM_PINS = 24,
    parameter int         ADDR_W   = 12,
    parameter logic [7:0] VERSION  = 8'h20,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [2:0]        acc_size,
    input logic [31:0]       acc_wdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              svc_req,
    input logic              cnt_clr,
    input logic [PIN_W-1:0]  cnt_pin,
    input logic              eoi_valid,
    input logic [7:0]        eoi_vec
);
    localparam bit EOI_ON = (VERSION != 8'h11);

    logic [7:0] shadow_idx;
    logic       win_acc, win_full, in_tbl, out_tbl, eoi_full;
    logic [7:0] pin_raw;

    // Shadow of the index register, taken from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_idx <= 8'd0;
        else if (acc_valid && acc_write && acc_addr[7:0] == 8'h00)
            shadow_idx <= acc_wdata[7:0];
    end

    // Classify the current access against the shadow index.
    always_comb begin
        pin_raw  = (shadow_idx - 8'h10) >> 1;
        win_acc  = acc_valid && acc_addr[7:0] == 8'h10;
        win_full = win_acc && acc_size == 3'd4;
        in_tbl   = shadow_idx >= 8'h10 && 32'(pin_raw) < NUM_PINS;
        out_tbl  = !in_tbl && shadow_idx > 8'h02;
        eoi_full = acc_valid && acc_write && acc_addr[7:0] == 8'h40 && acc_size == 3'd4;
    end

    a_r3_size_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && acc_size != 3'd4) |=> (!svc_req && rd_data == 32'd0));

    a_r9_service_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (win_full && acc_write && in_tbl) |=>
            (svc_req && cnt_clr && cnt_pin == $past(pin_raw[PIN_W-1:0])));

    a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (win_full && out_tbl) |=> (!svc_req && !cnt_clr && rd_data == 32'd0));

    a_r10_eoi_gate: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_full |=> (eoi_valid == EOI_ON && (!EOI_ON || eoi_vec == $past(acc_wdata[7:0]))));

    a_r11_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);

    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> (!rd_valid && rd_data == 32'd0));
endmodule

bind riw_ctrl riw_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .VERSION  (VER_EFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .svc_req   (svc_req),
    .cnt_clr   (cnt_clr),
    .cnt_pin   (cnt_pin),
    .eoi_valid (eoi_valid),
    .eoi_vec   (eoi_vec)
);

// File: tb/riw_ctrl_tb.sv
// Directed bench for riw_ctrl: a default instance at version 0x20 and a second
// instance at version 0x11 share all inputs.
module riw_ctrl_tb;
    localparam int NP    = 24;
    localparam int AW    = 12;
    localparam int PIN_W = $clog2(NP);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic             acc_write = 1'b0;
    logic [AW-1:0]    acc_addr = '0;
    logic [2:0]       acc_size = 3'd4;
    logic [31:0]      acc_wdata = '0;
    logic             st_valid = 1'b0;
    logic [PIN_W-1:0] st_pin = '0;
    logic             st_dlv = 1'b0;
    logic             st_rirr = 1'b0;
    logic [PIN_W-1:0] look_pin = '0;

    logic             rd_valid, rd_valid11;
    logic [31:0]      rd_data, rd_data11;
    logic [63:0]      look_entry, look_entry11;
    logic             svc_req, svc_req11, cnt_clr, cnt_clr11;
    logic [PIN_W-1:0] cnt_pin, cnt_pin11;
    logic             eoi_valid, eoi_valid11;
    logic [7:0]       eoi_vec, eoi_vec11;

    int checks = 0;
    int errors = 0;

    // Sampled results of the last access.
    logic [31:0] s_rdata, s_rdata11;
    logic        s_rvalid, s_svc, s_clr, s_eoi, s_eoi11;
    logic [PIN_W-1:0] s_pin;
    logic [7:0]  s_vec;

    always #5 clk = ~clk;

    riw_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .VERSION(8'h20)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .st_valid(st_valid),
        .st_pin(st_pin), .st_dlv(st_dlv), .st_rirr(st_rirr), .look_pin(look_pin),
        .look_entry(look_entry), .svc_req(svc_req), .cnt_clr(cnt_clr),
        .cnt_pin(cnt_pin), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec)
    );

    riw_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .VERSION(8'h11)) u_dut11 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid11), .rd_data(rd_data11), .st_valid(st_valid),
        .st_pin(st_pin), .st_dlv(st_dlv), .st_rirr(st_rirr), .look_pin(look_pin),
        .look_entry(look_entry11), .svc_req(svc_req11), .cnt_clr(cnt_clr11),
        .cnt_pin(cnt_pin11), .eoi_valid(eoi_valid11), .eoi_vec(eoi_vec11)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access; outputs are sampled at the following falling edge.
    task automatic acc(input logic wr, input logic [AW-1:0] a, input logic [2:0] sz,
                       input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        s_rdata = rd_data; s_rdata11 = rd_data11; s_rvalid = rd_valid;
        s_svc = svc_req; s_clr = cnt_clr; s_pin = cnt_pin;
        s_eoi = eoi_valid; s_eoi11 = eoi_valid11; s_vec = eoi_vec;
    endtask

    task automatic wr4(input logic [AW-1:0] a, input logic [31:0] d);
        acc(1'b1, a, 3'd4, d);
    endtask

    task automatic rd4(input logic [AW-1:0] a);
        acc(1'b0, a, 3'd4, 32'd0);
    endtask

    task automatic status(input int pin, input logic dlv, input logic rirr);
        @(negedge clk);
        st_valid = 1'b1; st_pin = PIN_W'(pin); st_dlv = dlv; st_rirr = rirr;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 svc_req", 64'(svc_req), 64'd0);
        chk("R1 eoi_valid", 64'(eoi_valid), 64'd0);
        look_pin = PIN_W'(5);
        #1 chk("R1 look entry 5", look_entry, 64'h0000_0000_0001_0000);
        rd4(12'h000);
        chk("R1 index reg", 64'(s_rdata), 64'd0);
        chk("R11 read strobe", 64'(s_rvalid), 64'd1);
        rd4(12'h010);
        chk("R1 id reads zero", 64'(s_rdata), 64'd0);
        wr4(12'h000, 32'h10);
        rd4(12'h010);
        chk("R1 entry0 low", 64'(s_rdata), 64'h0001_0000);
    endtask

    task automatic t_id_version();
        wr4(12'h000, 32'h00);
        wr4(12'h010, 32'hFFFF_FFFF);
        chk("R11 no rd_valid on write", 64'(s_rvalid), 64'd0);
        rd4(12'h010);
        chk("R4 id masked", 64'(s_rdata), 64'h0F00_0000);
        wr4(12'h000, 32'h02);
        rd4(12'h010);
        chk("R4 arb mirrors id", 64'(s_rdata), 64'h0F00_0000);
        wr4(12'h010, 32'h0000_0000);
        wr4(12'h000, 32'h00);
        rd4(12'h010);
        chk("R4 arb write ignored", 64'(s_rdata), 64'h0F00_0000);
        wr4(12'h000, 32'h01);
        wr4(12'h010, 32'hFFFF_FFFF);
        rd4(12'h010);
        chk("R5 version 0x20", 64'(s_rdata), 64'h0017_0020);
        chk("R5 version 0x11", 64'(s_rdata11), 64'h0017_0011);
    endtask

    task automatic t_alias_offsets();
        wr4(12'h700, 32'h12);
        rd4(12'hA00);
        chk("R2 index alias", 64'(s_rdata), 64'h12);
        wr4(12'hF10, 32'h0000_8031);
        chk("R9 svc via alias", 64'(s_svc), 64'd1);
        chk("R9 cnt_clr", 64'(s_clr), 64'd1);
        chk("R9 cnt_pin", 64'(s_pin), 64'd1);
        @(negedge clk);
        chk("R9 single pulse", 64'(svc_req), 64'd0);
        rd4(12'h010);
        chk("R6 entry1 low", 64'(s_rdata), 64'h0000_8031);
        wr4(12'h000, 32'h13);
        wr4(12'h010, 32'hAB00_0000);
        chk("R9 pin on high half", 64'(s_pin), 64'd1);
        look_pin = PIN_W'(1);
        #1 chk("R12 lookup entry1", look_entry, 64'hAB00_0000_0000_8031);
        look_pin = PIN_W'(31);
        #1 chk("R12 lookup out of range", look_entry, 64'd0);
        rd4(12'h020);
        chk("R2 unmapped offset", 64'(s_rdata), 64'd0);
    endtask

    task automatic t_size();
        wr4(12'h000, 32'h12);
        acc(1'b1, 12'h010, 3'd2, 32'h0000_0000);
        chk("R3 short write no svc", 64'(s_svc), 64'd0);
        acc(1'b0, 12'h010, 3'd1, 32'd0);
        chk("R3 short read zero", 64'(s_rdata), 64'd0);
        rd4(12'h010);
        chk("R3 entry unchanged", 64'(s_rdata), 64'h0000_8031);
        acc(1'b1, 12'h040, 3'd2, 32'h55);
        chk("R3 short eoi ignored", 64'(s_eoi), 64'd0);
    endtask

    task automatic t_status_bits();
        status(1, 1'b1, 1'b1);
        rd4(12'h010);
        chk("R7 status port sets bits", 64'(s_rdata), 64'h0000_D031);
        wr4(12'h010, 32'h0000_8031);
        rd4(12'h010);
        chk("R7 bits survive level write", 64'(s_rdata), 64'h0000_D031);
        wr4(12'h010, 32'h0000_0031);
        rd4(12'h010);
        chk("R8 edge clears remote bit", 64'(s_rdata), 64'h0000_1031);
        status(1, 1'b1, 1'b1);
        rd4(12'h010);
        chk("R7 status on edge entry", 64'(s_rdata), 64'h0000_5031);
        wr4(12'h000, 32'h13);
        wr4(12'h010, 32'h1200_0000);
        wr4(12'h000, 32'h12);
        rd4(12'h010);
        chk("R8 high write clears remote", 64'(s_rdata), 64'h0000_1031);
    endtask

    task automatic t_range();
        wr4(12'h000, 32'h40);
        wr4(12'h010, 32'h0000_00AA);
        chk("R6 out of range no svc", 64'(s_svc), 64'd0);
        rd4(12'h010);
        chk("R6 out of range reads zero", 64'(s_rdata), 64'd0);
        wr4(12'h000, 32'h07);
        rd4(12'h010);
        chk("R6 gap index reads zero", 64'(s_rdata), 64'd0);
        wr4(12'h000, 32'h3F);
        wr4(12'h010, 32'h9900_0000);
        chk("R6 last entry svc", 64'(s_svc), 64'd1);
        chk("R6 last entry pin", 64'(s_pin), 64'd23);
        look_pin = PIN_W'(23);
        #1 chk("R6 last entry high", look_entry, 64'h9900_0000_0001_0000);
    endtask

    task automatic t_eoi();
        wr4(12'h040, 32'h1234_5678);
        chk("R10 eoi strobe v20", 64'(s_eoi), 64'd1);
        chk("R10 eoi vector", 64'(s_vec), 64'h78);
        chk("R10 eoi gated v11", 64'(s_eoi11), 64'd0);
        wr4(12'h340, 32'h0000_00C3);
        chk("R10 eoi alias vector", 64'(s_vec), 64'hC3);
        @(negedge clk);
        chk("R10 eoi single pulse", 64'(eoi_valid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id_version();
        t_alias_offsets();
        t_size();
        t_status_bits();
        t_range();
        t_eoi();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule